// File: doc/BRIEF.md
# Four-Digit Multiplexed Seven-Segment Scanner

This block drives a four-digit seven-segment display in which the seven segment lines are wired in parallel to every digit and each digit has its own enable line. Both the enables and the segment lines are active low. The block takes four BCD digits packed into one 16-bit word and shows them one digit at a time. For each digit it pulls only that digit's enable low and places the decoded glyph on the shared segment lines.

A free-running counter sets how long each digit stays lit. Its top two bits pick the active digit. With the default width and a 100 MHz clock, each digit is held for 2^17 cycles. That gives about 763 Hz per digit and about 190 Hz for the whole display, well above the rate at which flicker can be seen. A smaller width shortens the dwell for simulation. The enable and the glyph are loaded into output registers on the same clock edge, so they never disagree.

Top module: `seg_scan`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `an_n = 4'hF` (all digits off) and `seg_n = 7'h7F` (all segments off).
- R2: At most one bit of `an_n` is low in any cycle. After the first clock edge that follows reset, exactly one bit is low.
- R3: Digit i is bits [4i+3:4i] of `bcd` and is enabled by driving `an_n[i]` low. Digit 0 is the rightmost. The scan goes 0, 1, 2, 3 and then back to 0, starting at digit 0 after reset.
- R4: Each digit stays enabled for exactly 2^(CNT_W-2) consecutive cycles. The default CNT_W of 19 gives 131072 cycles, about 763 Hz per digit at 100 MHz.
- R5: For codes 0 to 9, `seg_n` = {a,b,c,d,e,f,g}, with a in bit 6 and 0 meaning lit. The values are 0:0000001, 1:1001111, 2:0010010, 3:0000110, 4:1001100, 5:0100100, 6:0100000, 7:0001111, 8:0000000, 9:0000100.
- R6: Codes 10 to 15 produce `seg_n = 7'b1111111` (digit dark).
- R7: The glyph on `seg_n` always belongs to the digit whose enable is low in the same cycle.
- R8: A change of the selected digit's value appears on `seg_n` one clock edge after it is applied, without waiting for the next scan.
- R9: A reset applied in the middle of a scan darkens the display, and scanning starts again from digit 0 for a full dwell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| bcd | input | 16 | Four packed BCD digits, digit i in bits [4i+3:4i] |
| an_n | output | 4 | Active-low digit enables, bit i for digit i |
| seg_n | output | 7 | Active-low segments, bit 6 = a down to bit 0 = g |

## Verification
The bench targets the edges of the scan:
- The first digit after reset must get a full dwell. A counter off by one would shorten it, or would start on digit 1.
- The wrap from digit 3 back to digit 0 must land on digit 0. A rotation in the wrong direction would enable digit 2 instead.
- The six invalid codes must go dark. A decoder without a default would show leftover or arbitrary segments.
- A digit value changed while that digit is lit must appear within one cycle.
- A reset in the middle of a frame must blank both outputs at once. A stale register would leave one digit lit, and a wrong glyph would light it with the neighbour's segments.

// File: rtl/seg_scan.sv
module seg_scan #(
  parameter int CNT_W = 19
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bcd,
  output logic [3:0]  an_n,
  output logic [6:0]  seg_n
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] tick;
  logic [1:0]       sel;
  logic [3:0]       nib;

  assign sel = tick[CNT_W-1 -: 2];
  assign nib = bcd[{sel, 2'b00} +: 4];

  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'd0:    glyph = 7'b0000001;
      4'd1:    glyph = 7'b1001111;
      4'd2:    glyph = 7'b0010010;
      4'd3:    glyph = 7'b0000110;
      4'd4:    glyph = 7'b1001100;
      4'd5:    glyph = 7'b0100100;
      4'd6:    glyph = 7'b0100000;
      4'd7:    glyph = 7'b0001111;
      4'd8:    glyph = 7'b0000000;
      4'd9:    glyph = 7'b0000100;
      default: glyph = 7'b1111111;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      tick  <= '0;
      an_n  <= 4'hF;
      seg_n <= 7'h7F;
    end else begin
      tick  <= tick + ONE;
      an_n  <= ~(4'b0001 << sel);
      seg_n <= glyph(nib);
    end
  end
endmodule

// File: rtl/seg_scan_props.sv
module seg_scan_props #(
  parameter int CNT_W = 19
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bcd,
  input logic [3:0]  an_n,
  input logic [6:0]  seg_n
);
  localparam int HOLD = 2 ** (CNT_W - 2);

  logic [3:0] prev_an;
  int         run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_an <= 4'hF;
      run     <= 0;
    end else begin
      prev_an <= an_n;
      run     <= (an_n != prev_an) ? 1 : run + 1;
    end
  end

  function automatic logic [3:0] picked(input logic [3:0] a, input logic [15:0] d);
    case (a)
      4'b1110: picked = d[3:0];
      4'b1101: picked = d[7:4];
      4'b1011: picked = d[11:8];
      4'b0111: picked = d[15:12];
      default: picked = 4'd0;
    endcase
  endfunction

  assert_reset_dark_R1: assert property (@(posedge clk)
    rst |=> (an_n == 4'hF && seg_n == 7'h7F));

  assert_single_anode_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~an_n));

  assert_scan_order_R3: assert property (@(posedge clk) disable iff (rst)
    (an_n != prev_an && prev_an != 4'hF) |-> an_n == {prev_an[2:0], prev_an[3]});

  assert_dwell_R4: assert property (@(posedge clk) disable iff (rst)
    (an_n != prev_an && prev_an != 4'hF) |-> run == HOLD);

  assert_dark_code_R6: assert property (@(posedge clk) disable iff (rst)
    (an_n != 4'hF && picked(an_n, $past(bcd)) > 4'd9) |-> seg_n == 7'h7F);
endmodule

bind seg_scan seg_scan_props #(.CNT_W(CNT_W)) props (
  .clk(clk), .rst(rst), .bcd(bcd), .an_n(an_n), .seg_n(seg_n)
);

// File: tb/seg_scan_test.sv
module seg_scan_test;
  localparam int PERIOD = 10;
  localparam int CNT_W  = 4;
  localparam int HOLD   = 2 ** (CNT_W - 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bcd = 16'h0000;
  logic [3:0]  an_n;
  logic [6:0]  seg_n;
  int          edges = 0;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  seg_scan #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .bcd(bcd), .an_n(an_n), .seg_n(seg_n)
  );

  always #(PERIOD / 2) clk = ~clk;

  always @(posedge clk) edges <= rst ? 0 : edges + 1;

  function automatic logic [6:0] want_glyph(input logic [3:0] v);
    case (v)
      4'd0: want_glyph = 7'b0000001;
      4'd1: want_glyph = 7'b1001111;
      4'd2: want_glyph = 7'b0010010;
      4'd3: want_glyph = 7'b0000110;
      4'd4: want_glyph = 7'b1001100;
      4'd5: want_glyph = 7'b0100100;
      4'd6: want_glyph = 7'b0100000;
      4'd7: want_glyph = 7'b0001111;
      4'd8: want_glyph = 7'b0000000;
      4'd9: want_glyph = 7'b0000100;
      default: want_glyph = 7'b1111111;
    endcase
  endfunction

  task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got an_n/seg_n=%h exp=%h at edge %0d", tag, got, exp, edges);
    end
  endtask

  task automatic scan_check(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (edges == 0) check(tag, {an_n, seg_n}, {4'hF, 7'h7F});
      else begin
        int idx;
        idx = ((edges - 1) / HOLD) % 4;
        check(tag, {an_n, seg_n}, {~(4'b0001 << idx), want_glyph(bcd[idx*4 +: 4])});
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset dark", {an_n, seg_n}, {4'hF, 7'h7F});
    rst = 1'b0;
  endtask

  task automatic t_first_dwell();
    bcd = 16'h4321;
    @(negedge clk);
    check("R3 first digit 0", {an_n, seg_n}, {4'b1110, want_glyph(4'd1)});
    repeat (HOLD - 1) @(negedge clk);
    check("R4 dwell held", {an_n, seg_n}, {4'b1110, want_glyph(4'd1)});
    @(negedge clk);
    check("R3 next digit 1", {an_n, seg_n}, {4'b1101, want_glyph(4'd2)});
  endtask

  task automatic t_frames();
    bcd = 16'h9876;
    scan_check(4 * HOLD * 2, "R2 R3 R5 R7 frame 9876");
    bcd = 16'h5432;
    scan_check(4 * HOLD, "R5 R7 frame 5432");
    bcd = 16'h1098;
    scan_check(4 * HOLD, "R5 R7 frame 1098");
  endtask

  task automatic t_bad_codes();
    bcd = 16'hABCD;
    scan_check(4 * HOLD, "R6 codes A-D dark");
    bcd = 16'hEF0F;
    scan_check(4 * HOLD, "R6 codes E F dark");
  endtask

  task automatic t_live_change();
    bcd = 16'h0000;
    while (!(edges > 0 && ((edges - 1) / HOLD) % 4 == 2 && (edges - 1) % HOLD == 0))
      @(negedge clk);
    bcd = 16'h0700;
    @(negedge clk);
    check("R8 live update", {an_n, seg_n}, {4'b1011, want_glyph(4'd7)});
    scan_check(HOLD, "R8 after update");
  endtask

  task automatic t_mid_reset();
    bcd = 16'h3579;
    scan_check(HOLD + 2, "R9 pre reset");
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset blanks", {an_n, seg_n}, {4'hF, 7'h7F});
    rst = 1'b0;
    scan_check(4 * HOLD + 1, "R9 restart at digit 0");
  endtask

  initial begin
    t_reset();
    t_first_dwell();
    t_frames();
    t_bad_codes();
    t_live_change();
    t_mid_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule